// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is a clocked master for a 3-wire serial analog-to-digital converter link. Several converters share one serial clock, one command line and one result line, and each converter has its own active-low chip select. While enabled, the sequencer runs conversion frames back to back. In each frame it lowers the chip select of the addressed converter and waits a short settling time. It then issues ten serial clock pulses. During the first eight pulses it sends an 8-bit configuration word, most significant bit first. Over all ten pulses it collects a 10-bit result, also most significant bit first.

At the end of a frame the result is split into two bytes. The upper byte holds the eight leading bits, so bit 9 (magnitude MSB or sign) sits at the top. The lower byte holds the two trailing bits, left-justified, with zeros below them. A one-cycle strobe marks both bytes as new. The chip select then stays high for a programmed conversion gap before the next frame may start.

The serial clock is derived from the system clock by a divider input. The configuration word, divider, gap length and device select are all captured when a frame starts.

Top module: `adc_frame_seq`

## Requirements
- R1: Out of reset and between frames, every `csN` line is high, `sclk` is low and `resValid` is low. `resHi` and `resLo` reset to zero.
- R2: During a frame only `csN[devSel]` is low. `devSel` is sampled at frame start, and all other chip selects stay high.
- R3: The effective divider is `max(clkDiv, 2)`. Each `sclk` period lasts that many system cycles, with a high phase of `floor(eff/2)` cycles and a low phase of the remainder.
- R4: A frame begins with chip select low and `sclk` low for one low-phase length before the first rising edge of `sclk`.
- R5: `cfgWord` is presented on `sdo` MSB first, one bit per pulse, during pulses 1 to 8. Each bit is valid at the rising edge of its pulse. `sdo` is 0 at pulses 9 and 10.
- R6: Each frame has exactly ten `sclk` pulses. `sdi` is sampled at each rising edge, using the value it had just before that edge.
- R7: `resHi` equals the first eight received bits, the first received bit being bit 7.
- R8: `resLo` holds the ninth received bit in bit 7 and the tenth in bit 6, and bits 5 to 0 are 0.
- R9: `resValid` is a single-cycle pulse that updates both bytes. It is asserted in the first cycle after the frame with all chip selects high.
- R10: While `enable` stays high, consecutive frames are separated by exactly `max(gapCycles,1)+1` cycles with all chip selects high.
- R11: Dropping `enable` during a frame lets that frame complete, and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run frames continuously while high |
| cfgWord | input | 8 | Configuration word sent each frame |
| clkDiv | input | DIV_W | System cycles per serial clock period (values below 2 act as 2) |
| gapCycles | input | GAP_W | Conversion gap length in cycles (0 acts as 1) |
| devSel | input | DEV_W | Index of the converter addressed by the next frame |
| sdi | input | 1 | Serial result line from the converters |
| sclk | output | 1 | Shared serial clock, idles low |
| sdo | output | 1 | Shared serial command line |
| csN | output | NUM_DEV | Active-low chip select per converter |
| resHi | output | 8 | Result bits 9 down to 2 |
| resLo | output | 8 | Result bits 1 and 0 in positions 7 and 6, zeros below |
| resValid | output | 1 | One-cycle strobe marking new result bytes |

## Verification
A wrong bit counter shows up within one frame as a pulse count other than ten. It also shifts the command bits off their pulses and moves the position of the valid strobe. A phase counter that is loaded wrongly changes the measured high, low or settling lengths at the very first serial clock edge. A bad latch of the device select or gap is visible at the chip select lines: either another line drops low, or the high time between two frames differs from the programmed length. A fault in the packing path appears as mismatched result bytes on the first strobe.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } seqState_t;

  typedef struct packed {
    logic load;      // frame start: capture settings, preload shifters
    logic sample;    // sclk rising: take sdi
    logic shiftOut;  // sclk falling: advance command bit
    logic finish;    // last low phase done: publish result
  } seqStrobe_t;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int GAP_W    = 8,
  parameter int RES_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [GAP_W-1:0] gapCycles,
  output seqStrobe_t       strobe,
  output logic             frameActive,
  output logic             sclk
);
  localparam int CNT_W = (DIV_W > GAP_W) ? DIV_W : GAP_W;
  localparam int BIT_W = $clog2(RES_BITS + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(RES_BITS - 1);

  seqState_t        state;
  logic [CNT_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divLat;
  logic [GAP_W-1:0] gapLat;
  logic             phaseDone;

  function automatic logic [CNT_W-1:0] hiLen(input logic [DIV_W-1:0] d);
    logic [DIV_W-1:0] eff;
    eff = (d < DIV_W'(2)) ? DIV_W'(2) : d;
    return CNT_W'(eff >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] loLen(input logic [DIV_W-1:0] d);
    logic [DIV_W-1:0] eff;
    eff = (d < DIV_W'(2)) ? DIV_W'(2) : d;
    return CNT_W'(eff - (eff >> 1));
  endfunction

  assign phaseDone   = (phaseCnt == '0);
  assign frameActive = (state == ST_SETTLE) || (state == ST_HIGH) || (state == ST_LOW);
  assign sclk        = (state == ST_HIGH);

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == ST_IDLE) && enable;
    strobe.sample   = phaseDone && ((state == ST_SETTLE) ||
                                    ((state == ST_LOW) && (bitCnt != LAST_BIT)));
    strobe.shiftOut = phaseDone && (state == ST_HIGH);
    strobe.finish   = phaseDone && (state == ST_LOW) && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      divLat   <= '0;
      gapLat   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (enable) begin
          state    <= ST_SETTLE;
          divLat   <= clkDiv;
          gapLat   <= gapCycles;
          phaseCnt <= loLen(clkDiv) - CNT_W'(1);
          bitCnt   <= '0;
        end
        ST_SETTLE: if (phaseDone) begin
          state    <= ST_HIGH;
          phaseCnt <= hiLen(divLat) - CNT_W'(1);
        end else phaseCnt <= phaseCnt - CNT_W'(1);
        ST_HIGH: if (phaseDone) begin
          state    <= ST_LOW;
          phaseCnt <= loLen(divLat) - CNT_W'(1);
        end else phaseCnt <= phaseCnt - CNT_W'(1);
        ST_LOW: if (phaseDone) begin
          if (bitCnt == LAST_BIT) begin
            state    <= ST_GAP;
            phaseCnt <= (gapLat == '0) ? '0 : CNT_W'(gapLat) - CNT_W'(1);
          end else begin
            state    <= ST_HIGH;
            bitCnt   <= bitCnt + BIT_W'(1);
            phaseCnt <= hiLen(divLat) - CNT_W'(1);
          end
        end else phaseCnt <= phaseCnt - CNT_W'(1);
        ST_GAP: if (phaseDone) state <= ST_IDLE;
                else phaseCnt <= phaseCnt - CNT_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> frameActive); // R1
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT); // R6
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && $past(frameActive)) |-> $stable(divLat)); // R3
  AST_FINISH_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !frameActive); // R9
endmodule

// File: rtl/adcseq_dpath.sv
module adcseq_dpath
  import adcseq_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int DEV_W    = 2,
  parameter int CFG_BITS = 8,
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                frameActive,
  input  logic [CFG_BITS-1:0] cfgWord,
  input  logic [DEV_W-1:0]    devSel,
  input  logic                sdi,
  output logic                sdo,
  output logic [NUM_DEV-1:0]  csN,
  output logic [7:0]          resHi,
  output logic [7:0]          resLo,
  output logic                resValid
);
  localparam int LO_N = RES_BITS - 8;

  logic [CFG_BITS-1:0] txShift;
  logic [RES_BITS-1:0] rxShift;
  logic [DEV_W-1:0]    devLat;

  assign sdo = txShift[CFG_BITS-1];

  generate
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
      assign csN[i] = !(frameActive && (devLat == DEV_W'(i)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      devLat   <= '0;
      resHi    <= '0;
      resLo    <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strobe.finish;
      if (strobe.load) begin
        txShift <= cfgWord;
        rxShift <= '0;
        devLat  <= devSel;
      end
      if (strobe.sample)   rxShift <= {rxShift[RES_BITS-2:0], sdi};
      if (strobe.shiftOut) txShift <= {txShift[CFG_BITS-2:0], 1'b0};
      if (strobe.finish) begin
        resHi <= rxShift[RES_BITS-1:LO_N];
        resLo <= {rxShift[LO_N-1:0], {(8-LO_N){1'b0}}};
      end
    end
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R9
  AST_VALID_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (&csN)); // R9
  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && $past(frameActive)) |-> $stable(csN)); // R2
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adcseq_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  parameter int DIV_W   = 8,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [7:0]         cfgWord,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic [GAP_W-1:0]   gapCycles,
  input  logic [DEV_W-1:0]   devSel,
  input  logic               sdi,
  output logic               sclk,
  output logic               sdo,
  output logic [NUM_DEV-1:0] csN,
  output logic [7:0]         resHi,
  output logic [7:0]         resLo,
  output logic               resValid
);
  localparam int CFG_BITS = 8;
  localparam int RES_BITS = 10;

  seqStrobe_t strobe;
  logic       frameActive;

  adcseq_ctrl #(.DIV_W(DIV_W), .GAP_W(GAP_W), .RES_BITS(RES_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clkDiv(clkDiv),
    .gapCycles(gapCycles), .strobe(strobe), .frameActive(frameActive),
    .sclk(sclk)
  );

  adcseq_dpath #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .CFG_BITS(CFG_BITS),
                 .RES_BITS(RES_BITS)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameActive(frameActive),
    .cfgWord(cfgWord), .devSel(devSel), .sdi(sdi), .sdo(sdo), .csN(csN),
    .resHi(resHi), .resLo(resLo), .resValid(resValid)
  );
endmodule

// File: tb/adc_frame_seq_tb_top.sv
module adc_frame_seq_tb_top;
  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] div;
    logic [7:0] gap;
    logic [1:0] dev;
    logic [9:0] res;
  } vec_t;

  localparam vec_t VECS [0:4] = '{
    '{8'h0D, 8'd4, 8'd3, 2'd0, 10'h2A5},
    '{8'hB3, 8'd5, 8'd1, 2'd1, 10'h3FF},
    '{8'h80, 8'd2, 8'd0, 2'd2, 10'h000},
    '{8'h5A, 8'd0, 8'd2, 2'd3, 10'h155},
    '{8'hFF, 8'd9, 8'd4, 2'd1, 10'h203}
  };

  logic       clk = 0, rstN = 0, enable = 0, sdi = 0;
  logic [7:0] cfgWord = 0, clkDiv = 4, gapCycles = 1;
  logic [1:0] devSel = 0;
  logic       sclk, sdo, resValid;
  logic [3:0] csN;
  logic [7:0] resHi, resLo;

  int checks = 0, fails = 0;
  int frames = 0, pulses = 0, settleLen = 0, hiLen = 0, curHigh = 0;
  int period = 0, lastRise = 0, cyc = 0, highRun = 0, highRunLast = 0;
  int validCount = 0, validDouble = 0, bitIdx = 0;
  logic [3:0] lowSel = '1;
  logic [9:0] sdoBits = 0, resModel = 0;
  logic prevCsLow = 0, prevSclk = 0, prevValid = 0, csAtValid = 0;

  always #10 clk = ~clk;

  adc_frame_seq dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWord(cfgWord),
    .clkDiv(clkDiv), .gapCycles(gapCycles), .devSel(devSel), .sdi(sdi),
    .sclk(sclk), .sdo(sdo), .csN(csN), .resHi(resHi), .resLo(resLo),
    .resValid(resValid)
  );

  // Port monitor plus converter model; sdi changes on falling sclk
  always @(negedge clk) begin
    logic csLow;
    cyc++;
    csLow = ~&csN;
    if (csLow && !prevCsLow) begin
      frames++; highRunLast = highRun; highRun = 0; pulses = 0;
      settleLen = 0; sdoBits = 0; lowSel = csN;
      bitIdx = 9; sdi = resModel[9];
    end
    if (!csLow) highRun++;
    if (csLow && pulses == 0 && !sclk) settleLen++;
    if (sclk && !prevSclk) begin
      pulses++; sdoBits = {sdoBits[8:0], sdo};
      if (pulses == 2) period = cyc - lastRise;
      lastRise = cyc; curHigh = 1;
    end else if (sclk) curHigh++;
    if (!sclk && prevSclk) begin
      hiLen = curHigh;
      bitIdx--;
      sdi = (bitIdx >= 0) ? resModel[bitIdx] : 1'b0;
    end
    if (resValid) begin validCount++; csAtValid = &csN; end
    if (resValid && prevValid) validDouble++;
    prevCsLow = csLow; prevSclk = sclk; prevValid = resValid;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic run_vec(input vec_t v);
    int f0, vc0, eff, h, l;
    eff = (v.div < 2) ? 2 : int'(v.div);
    h = eff / 2; l = eff - h;
    cfgWord = v.cfg; clkDiv = v.div; gapCycles = v.gap; devSel = v.dev;
    resModel = v.res;
    f0 = frames; vc0 = validCount;
    enable = 1;
    while (frames == f0) tick(1);
    enable = 0;
    while (validCount == vc0) tick(1);
    tick(1);
    check(lowSel == ~(4'b1 << v.dev), "R2 addressed cs", lowSel, ~(4'b1 << v.dev));
    check(pulses == 10, "R6 pulse count", pulses, 10);
    check(period == eff, "R3 sclk period", period, eff);
    check(hiLen == h, "R3 sclk high phase", hiLen, h);
    check(settleLen == l, "R4 settle length", settleLen, l);
    check(sdoBits == {v.cfg, 2'b00}, "R5 command bits", sdoBits, {v.cfg, 2'b00});
    check(resHi == v.res[9:2], "R7 upper byte", resHi, v.res[9:2]);
    check(resLo == {v.res[1:0], 6'b0}, "R8 lower byte", resLo, {v.res[1:0], 6'b0});
    check(csAtValid, "R9 cs high at strobe", csAtValid, 1);
    tick(40);
    check(frames == f0 + 1, "R11 no frame after disable", frames, f0 + 1);
    check(validDouble == 0, "R9 single-cycle strobe", validDouble, 0);
  endtask

  task automatic gap_test(input int g);
    int f0, eg;
    eg = (g == 0) ? 1 : g;
    clkDiv = 3; gapCycles = 8'(g); devSel = 2; resModel = 10'h1C3;
    f0 = frames;
    enable = 1;
    while (frames < f0 + 2) tick(1);
    enable = 0;
    check(highRunLast == eg + 1, "R10 gap length", highRunLast, eg + 1);
    tick(60);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_test();
  end

  initial begin
    tick(3);
    check(&csN, "R1 cs idle in reset", csN, 4'hF);
    check(!sclk, "R1 sclk low in reset", sclk, 0);
    rstN = 1;
    tick(5);
    check(&csN && !sclk && !resValid, "R1 idle after reset", {csN, sclk, resValid}, 6'h3C);
    check(resHi == 0 && resLo == 0, "R1 result bytes reset", {resHi, resLo}, 0);
    foreach (VECS[i]) run_vec(VECS[i]);
    gap_test(5);
    gap_test(0);
    gap_test(1);
    check(&csN && !sclk, "R1 idle at end", {csN, sclk}, 5'h1E);
    finish_test();
  end
endmodule